// File: doc/BRIEF.md
# Network Link LED Status Indicator

This block drives one status LED of a 10/100 Ethernet port. A 16-bit control word selects which status sources may light the LED. The level sources are link up, full-duplex link and 100 Mbps operation. The event sources are receive address match and wake-frame detection. The enabled sources are ORed together into a single status value.

An optional pulse stretcher keeps that value on for a fixed number of clocks after the last qualifying event, so that single-cycle events remain visible. The status value is read back in the top bit of the control word. A pad stage turns it into an output value and an output enable. The pad can run as an active-low open-drain output or as a driven push-pull output, or it can be turned off completely.

Register access uses a synchronous write strobe with write data and a combinational read of the whole word. The event inputs are single-cycle pulses. The level inputs are sampled on every clock. The active-low asynchronous reset is the hardware reset of the control word.

Top module: `led_status_ind`

## Requirements
- R1: After reset the control word reads 0x1080: the stretch enable (bit 7) and the speed enable (bit 12) are 1, and every other control bit is 0.
- R2: A write stores bits 14, 13, 12, 9, 8, 7, 6 and 5. Bits 11 to 10 and 4 to 0 always read 0, and writes to them have no effect.
- R3: Read bit 15 is the status: the OR of link (enable bit 6), receive match (enable bit 5), 100 Mbps (enable bit 12), wake detect (enable bit 9) and full-duplex link (enable bit 8), each gated by its enable. A disabled source has no effect, and a write to bit 15 is ignored.
- R4: The full-duplex source contributes 1 only while link up and full duplex are both high.
- R5: With stretch enabled (bit 7 = 1), the status stays 1 for HOLD_CYC clocks after the last cycle in which any enabled source was high. Each new event restarts that window.
- R6: With stretch disabled, the status follows the ORed sources in the same cycle and does not hold.
- R7: With polarity bit 14 = 1 and disable bit 13 = 0, the output enable is 1 and the pad value equals the status.
- R8: With bit 14 = 0 and bit 13 = 0 (open drain), the pad value is 0 and the output enable equals the status.
- R9: With bit 13 = 1, the output enable and the pad value are both 0, whatever the other settings are.
- R10: The status read in bit 15 does not depend on the polarity bit or the disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| we_i | input | 1 | Control word write strobe |
| wdata_i | input | 16 | Control word write data |
| rdata_o | output | 16 | Control word read-back, status in bit 15 |
| link_pass_i | input | 1 | Link up level |
| full_duplex_i | input | 1 | Full-duplex operation level |
| speed100_i | input | 1 | 100 Mbps operation level |
| rx_match_i | input | 1 | Receive address match pulse |
| wake_det_i | input | 1 | Wake frame detected pulse |
| pad_o | output | 1 | LED pad output value |
| pad_oe_o | output | 1 | LED pad output enable, active high |

## Verification
The bench measures the exact length of the stretched on-time after one event. A counter that is off by one shows one cycle too many or too few. It also checks that a second event restarts the hold window; a design that keeps counting from the first event goes dark early. It checks full duplex without link up, which a design that ignores the link qualifier would light. It also confirms that polarity and disable change only the pad pins and never the status read back. A cycle-by-cycle model catches any mix-up between the open-drain and push-pull modes.

// File: rtl/led_ind_pkg.sv
package led_ind_pkg;
  localparam int RW = 16;
  localparam int B_STAT = 15;
  localparam int B_POL  = 14;
  localparam int B_DIS  = 13;
  localparam int B_SPD  = 12;
  localparam int B_WAKE = 9;
  localparam int B_FDX  = 8;
  localparam int B_STR  = 7;
  localparam int B_LNK  = 6;
  localparam int B_RXM  = 5;
  localparam int NSRC   = 5;

  localparam logic [RW-1:0] WR_MASK = (RW'(1) << B_POL) | (RW'(1) << B_DIS) |
                                      (RW'(1) << B_SPD) | (RW'(1) << B_WAKE) |
                                      (RW'(1) << B_FDX) | (RW'(1) << B_STR) |
                                      (RW'(1) << B_LNK) | (RW'(1) << B_RXM);
  localparam logic [RW-1:0] RST_VAL = (RW'(1) << B_SPD) | (RW'(1) << B_STR);

  // source index order inside the OR
  typedef enum logic [2:0] {
    SRC_LNK  = 3'd0,
    SRC_FDX  = 3'd1,
    SRC_RXM  = 3'd2,
    SRC_SPD  = 3'd3,
    SRC_WAKE = 3'd4
  } led_src_e;
endpackage

// File: rtl/led_ctrl_reg.sv
module led_ctrl_reg
  import led_ind_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] word_o
);
  logic [RW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= RST_VAL;
    else if (we_i) word_q <= wdata_i & WR_MASK;
  end

  assign word_o = word_q;
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import led_ind_pkg::*;
(
  input  logic [NSRC-1:0] en_i,
  input  logic            link_i,
  input  logic            fdx_i,
  input  logic            spd_i,
  input  logic            rxm_i,
  input  logic            wake_i,
  output logic            raw_o
);
  logic [NSRC-1:0] src;

  always_comb begin
    src           = '0;
    src[SRC_LNK]  = link_i;
    src[SRC_FDX]  = link_i & fdx_i;  // full duplex counts only with link up
    src[SRC_RXM]  = rxm_i;
    src[SRC_SPD]  = spd_i;
    src[SRC_WAKE] = wake_i;
  end

  assign raw_o = |(en_i & src);
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int HOLD_CYC = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic stat_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (raw_i)          cnt_q <= HOLD_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign stat_o = raw_i | (en_i & (cnt_q != '0));

  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HOLD_V);
endmodule

// File: rtl/led_pad_drv.sv
module led_pad_drv (
  input  logic pol_i,
  input  logic dis_i,
  input  logic stat_i,
  output logic pad_o,
  output logic pad_oe_o
);
  always_comb begin
    if (dis_i) begin
      pad_o    = 1'b0;
      pad_oe_o = 1'b0;
    end else if (pol_i) begin
      pad_o    = stat_i;
      pad_oe_o = 1'b1;
    end else begin
      pad_o    = 1'b0;     // open drain: pull low when lit
      pad_oe_o = stat_i;
    end
  end
endmodule

// File: rtl/led_status_ind.sv
module led_status_ind
  import led_ind_pkg::*;
#(
  parameter int HOLD_CYC = 65536
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output logic [RW-1:0] rdata_o,
  input  logic          link_pass_i,
  input  logic          full_duplex_i,
  input  logic          speed100_i,
  input  logic          rx_match_i,
  input  logic          wake_det_i,
  output logic          pad_o,
  output logic          pad_oe_o
);
  logic [RW-1:0]   word;
  logic [NSRC-1:0] en;
  logic            raw, stat;

  led_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .word_o  (word)
  );

  always_comb begin
    en           = '0;
    en[SRC_LNK]  = word[B_LNK];
    en[SRC_FDX]  = word[B_FDX];
    en[SRC_RXM]  = word[B_RXM];
    en[SRC_SPD]  = word[B_SPD];
    en[SRC_WAKE] = word[B_WAKE];
  end

  led_src_mux u_mux (
    .en_i   (en),
    .link_i (link_pass_i),
    .fdx_i  (full_duplex_i),
    .spd_i  (speed100_i),
    .rxm_i  (rx_match_i),
    .wake_i (wake_det_i),
    .raw_o  (raw)
  );

  led_stretch #(.HOLD_CYC(HOLD_CYC)) u_str (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (word[B_STR]),
    .raw_i  (raw),
    .stat_o (stat)
  );

  led_pad_drv u_pad (
    .pol_i    (word[B_POL]),
    .dis_i    (word[B_DIS]),
    .stat_i   (stat),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );

  assign rdata_o = word | (RW'(stat) << B_STAT);

  // assertions
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[11:10] == 2'b00 && rdata_o[4:0] == 5'b0);
  a_r3_raw_lights: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw |-> stat);
  a_r5_hold_after_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(word[B_STR]) && word[B_STR] && $past(raw) |-> stat);
  a_r6_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word[B_STR] |-> stat == raw);
  a_r7_totem_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word[B_POL] && !word[B_DIS] |-> pad_oe_o && pad_o == rdata_o[B_STAT]);
  a_r8_od_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word[B_POL] && !word[B_DIS] |-> !pad_o && pad_oe_o == rdata_o[B_STAT]);
  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word[B_DIS] |-> !pad_o && !pad_oe_o);
  a_r10_status_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[B_STAT] == stat);
endmodule

// File: tb/led_status_ind_tb_top.sv
`timescale 1ns/1ps
module led_status_ind_tb_top;
  localparam int HOLD = 8;
  localparam logic [15:0] MASK = 16'h73E0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic link = 0, fdx = 0, spd = 0, rxm = 0, wake = 0;
  logic pad, pad_oe;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;  // 250 MHz

  led_status_ind #(.HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .link_pass_i(link), .full_duplex_i(fdx), .speed100_i(spd),
    .rx_match_i(rxm), .wake_det_i(wake), .pad_o(pad), .pad_oe_o(pad_oe)
  );

  // reference model
  logic [15:0] m_ctrl;
  int rem;

  function automatic bit m_raw();
    return (m_ctrl[6] && link) || (m_ctrl[8] && link && fdx) ||
           (m_ctrl[5] && rxm) || (m_ctrl[12] && spd) || (m_ctrl[9] && wake);
  endfunction

  function automatic bit m_stat();
    return m_ctrl[7] ? (m_raw() || rem > 0) : m_raw();
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 16'h1080;
      rem = 0;
    end else begin
      if (!m_ctrl[7])    rem = 0;
      else if (m_raw())  rem = HOLD;
      else if (rem > 0)  rem = rem - 1;
      if (we) m_ctrl = wdata & MASK;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit st;
      logic [15:0] er;
      logic ep, eo;
      st = m_stat();
      er = m_ctrl | {st, 15'b0};
      if (m_ctrl[13])      begin ep = 0;  eo = 0;  end
      else if (m_ctrl[14]) begin ep = st; eo = 1;  end
      else                 begin ep = 0;  eo = st; end
      total++;
      if (rdata !== er || pad !== ep || pad_oe !== eo) begin
        bad++;
        $display("FAIL %s model: act rd=%h pad=%b oe=%b exp rd=%h pad=%b oe=%b",
                 cur_req, rdata, pad, pad_oe, er, ep, eo);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(posedge clk); #1; we = 1; wdata = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // one rx pulse, then count lit cycles over a window
  task automatic pulse_count(int gap, bit second, output int hi);
    hi = 0;
    @(posedge clk); #1; rxm = 1;
    @(negedge clk); if (rdata[15]) hi++;
    @(posedge clk); #1; rxm = 0;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); if (rdata[15]) hi++;
      @(posedge clk); #1;
    end
    if (second) begin
      rxm = 1;
      @(negedge clk); if (rdata[15]) hi++;
      @(posedge clk); #1; rxm = 0;
    end
    for (int i = 0; i < HOLD + 4; i++) begin
      @(negedge clk); if (rdata[15]) hi++;
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    int hi;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(rdata == 16'h1080, "R1", rdata, 16'h1080);

    cur_req = "R2";
    wr(16'hFFFF & ~16'h8000);
    @(negedge clk);
    chk(rdata[14:0] == 15'h73E0, "R2", rdata[14:0], 15'h73E0);
    wr(16'h0C1F);
    @(negedge clk);
    chk(rdata == 16'h0000, "R2", rdata, 0);

    cur_req = "R3";
    link = 1; spd = 1; fdx = 1;
    wr(16'h8000);                     // no enables, bit 15 write ignored
    @(negedge clk);
    chk(rdata == 16'h0000, "R3", rdata, 0);
    wr(16'h4040);                     // link enable, push-pull
    @(negedge clk);
    chk(rdata[15] == 1'b1, "R3", rdata[15], 1);
    cur_req = "R7";
    chk(pad == 1 && pad_oe == 1, "R7", {pad, pad_oe}, 2'b11);

    cur_req = "R4";
    link = 0; fdx = 1;
    wr(16'h4100);                     // only full-duplex enable
    @(negedge clk);
    chk(rdata[15] == 0, "R4", rdata[15], 0);
    step(1); link = 1; fdx = 0;
    @(negedge clk);
    chk(rdata[15] == 0, "R4", rdata[15], 0);
    step(1); fdx = 1;
    @(negedge clk);
    chk(rdata[15] == 1, "R4", rdata[15], 1);
    step(1); link = 0; fdx = 0; spd = 0;

    cur_req = "R5";
    wr(16'h40A0);                     // rx match + stretch
    pulse_count(0, 0, hi);
    chk(hi == HOLD + 1, "R5", hi, HOLD + 1);
    pulse_count(4, 1, hi);            // second event restarts window
    chk(hi == HOLD + 6, "R5", hi, HOLD + 6);

    cur_req = "R6";
    wr(16'h4020);
    pulse_count(0, 0, hi);
    chk(hi == 1, "R6", hi, 1);

    cur_req = "R8";
    wr(16'h0280);                     // open drain, wake + stretch
    @(negedge clk);
    chk(pad == 0 && pad_oe == 0, "R8", {pad, pad_oe}, 2'b00);
    @(posedge clk); #1 wake = 1;
    @(posedge clk); #1 wake = 0;
    @(negedge clk);
    chk(pad == 0 && pad_oe == 1, "R8", {pad, pad_oe}, 2'b01);
    step(HOLD + 2);

    cur_req = "R9";
    spd = 1;
    wr(16'h7000);
    @(negedge clk);
    chk(pad == 0 && pad_oe == 0, "R9", {pad, pad_oe}, 2'b00);
    cur_req = "R10";
    chk(rdata[15] == 1, "R10", rdata[15], 1);
    wr(16'h1000);
    @(negedge clk);
    chk(rdata[15] == 1, "R10", rdata[15], 1);
    spd = 0;
    step(3);
    finish_run();
  end
endmodule